// File: doc/BRIEF.md
# Conditional Branch and Skip Unit

This block resolves one control-transfer instruction per clock. It receives the 6-bit opcode, the branch target taken from operand A, the value of operand A, the value of operand B, the 12-bit flag word and two candidate sequential addresses from the address generator: the next instruction and the one after it. From these it chooses the next instruction pointer. When the instruction is one of the two decrementing branches, it also produces the decremented B value with a write-back strobe.

All values are 12-bit two's complement. Decrement wraps modulo 4096. The greater-than test treats B as signed. Flag-bit branches use B as a bit index into the flag word. Only the three condition flags can be read this way, and any other index reads as clear. The results are registered, so they appear one cycle after the inputs are presented. An opcode that is not a control transfer simply advances to the sequential address.

Top module: `br_skip_unit`

## Requirements
- R1: While rst_ni is low, nxt_o, wb_val_o and wb_en_o are all zero.
- R2: An opcode outside {5, 7..14} (for example 0 or 1) yields nxt_o = seq1_i and wb_en_o = 0.
- R3: Opcode 13 (unconditional jump) yields nxt_o = tgt_i and wb_en_o = 0.
- R4: Opcode 7 (decrement, branch if nonzero) yields wb_en_o = 1 and wb_val_o = (b_i - 1) mod 4096. nxt_o = tgt_i when that result is nonzero, otherwise seq1_i.
- R5: Opcode 8 (decrement, branch if zero) yields wb_en_o = 1 and wb_val_o = (b_i - 1) mod 4096. nxt_o = tgt_i when that result is zero, so b_i = 0 wraps to 0xFFF and does not branch.
- R6: Opcode 14 branches to tgt_i when b_i is zero. Opcode 12 branches when b_i is nonzero. Otherwise both give seq1_i.
- R7: Opcode 11 branches to tgt_i only when b_i, read as signed 12-bit, is greater than zero. So 0x7FF branches, while 0x000 and 0x800 do not.
- R8: Opcode 10 branches when flags_i[b_i] is set, and opcode 9 branches when it is clear. The readable flags are bit 11 (carry), bit 10 (zero) and bit 9 (success).
- R9: A flag index of 0..8 (the reserved and direction bits) or 12 or above reads as clear. Opcode 10 then never branches and opcode 9 always branches, whatever flags_i holds.
- R10: Opcode 5 (compare) yields nxt_o = seq2_i when a_i differs from b_i, and seq1_i when they are equal. wb_en_o = 0.
- R11: Each output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 6 | Opcode of the instruction being resolved |
| tgt_i | input | 12 | Branch target address from operand A |
| a_i | input | 12 | Value of operand A (compare) |
| b_i | input | 12 | Value of operand B (count, test value or flag index) |
| flags_i | input | 12 | Flag word: carry[11], zero[10], success[9], rest unreadable |
| seq1_i | input | 12 | Address of the following instruction |
| seq2_i | input | 12 | Address two instructions ahead (skip target) |
| nxt_o | output | 12 | Selected next instruction pointer |
| wb_val_o | output | 12 | Decremented B value |
| wb_en_o | output | 1 | B write-back strobe |

## Verification
The hardest cases are the wrap and sign boundaries. The decrement of zero must wrap to 0xFFF, and the signed test must reject 0x800 even though its magnitude is the largest. Both sit at single input values that a sweep of ordinary counts never reaches. The bench drives them as explicit vectors: B = 0 and B = 1 for both decrementing opcodes, and 0x7FF, 0x800 and 0x000 for the signed test. For the flag branches it sets every flag-word bit high, so any index below 9 exposes a read of a reserved or direction bit.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int OPW = 6;
  localparam logic [OPW-1:0] OP_CMP  = 6'd5;
  localparam logic [OPW-1:0] OP_DJN  = 6'd7;
  localparam logic [OPW-1:0] OP_DJZ  = 6'd8;
  localparam logic [OPW-1:0] OP_JMFC = 6'd9;
  localparam logic [OPW-1:0] OP_JMFS = 6'd10;
  localparam logic [OPW-1:0] OP_JMG  = 6'd11;
  localparam logic [OPW-1:0] OP_JMN  = 6'd12;
  localparam logic [OPW-1:0] OP_JMP  = 6'd13;
  localparam logic [OPW-1:0] OP_JMZ  = 6'd14;

  typedef enum logic [1:0] {SEL_SEQ1, SEL_TGT, SEL_SEQ2} nxt_sel_e;
endpackage

// File: rtl/br_flag_pick.sv
module br_flag_pick #(
  parameter int DW      = 12,
  parameter int FLAG_LO = 9
) (
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] idx_i,
  output logic          bit_o
);
  logic [DW-1:0] hit;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i >= FLAG_LO) begin : g_rd
      assign hit[i] = flags_i[i] && (idx_i == DW'(i));
    end else begin : g_blind
      assign hit[i] = 1'b0;
    end
  end

  assign bit_o = |hit;
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           flag_i,
  output nxt_sel_e       sel_o,
  output logic           wb_en_o,
  output logic [DW-1:0]  wb_val_o
);
  logic [DW-1:0] dec;
  logic          take;

  assign dec      = b_i - DW'(1);
  assign wb_val_o = dec;

  always_comb begin
    take    = 1'b0;
    wb_en_o = 1'b0;
    sel_o   = SEL_SEQ1;
    unique case (op_i)
      OP_DJN:  begin wb_en_o = 1'b1; take = (dec != '0); end
      OP_DJZ:  begin wb_en_o = 1'b1; take = (dec == '0); end
      OP_JMFC: take = !flag_i;
      OP_JMFS: take = flag_i;
      OP_JMG:  take = !b_i[DW-1] && (b_i != '0);
      OP_JMN:  take = (b_i != '0);
      OP_JMZ:  take = (b_i == '0);
      OP_JMP:  take = 1'b1;
      OP_CMP:  if (a_i != b_i) sel_o = SEL_SEQ2;
      default: ;
    endcase
    if (take) sel_o = SEL_TGT;
  end
endmodule

// File: rtl/br_skip_unit.sv
module br_skip_unit
  import br_pkg::*;
#(
  parameter int DW      = 12,
  parameter int FLAG_LO = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  tgt_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [DW-1:0]  flags_i,
  input  logic [DW-1:0]  seq1_i,
  input  logic [DW-1:0]  seq2_i,
  output logic [DW-1:0]  nxt_o,
  output logic [DW-1:0]  wb_val_o,
  output logic           wb_en_o
);
  logic          flag_bit;
  nxt_sel_e      sel;
  logic          wb_en_d;
  logic [DW-1:0] wb_val_d;
  logic [DW-1:0] nxt_d;

  br_flag_pick #(.DW(DW), .FLAG_LO(FLAG_LO)) u_pick (
    .flags_i (flags_i),
    .idx_i   (b_i),
    .bit_o   (flag_bit)
  );

  br_cond_eval #(.DW(DW)) u_eval (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .flag_i   (flag_bit),
    .sel_o    (sel),
    .wb_en_o  (wb_en_d),
    .wb_val_o (wb_val_d)
  );

  always_comb begin
    unique case (sel)
      SEL_TGT:  nxt_d = tgt_i;
      SEL_SEQ2: nxt_d = seq2_i;
      default:  nxt_d = seq1_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_o    <= '0;
      wb_val_o <= '0;
      wb_en_o  <= 1'b0;
    end else begin
      nxt_o    <= nxt_d;
      wb_val_o <= wb_en_d ? wb_val_d : '0;
      wb_en_o  <= wb_en_d;
    end
  end

  // history guard so $past never reaches before reset release
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !wb_en_o);

  p_wb_only_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    wb_en_o |-> ($past(op_i) == OP_DJN || $past(op_i) == OP_DJZ));

  p_dec_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    wb_en_o |-> (wb_val_o == DW'($past(b_i) - DW'(1))));

  p_jmp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) == OP_JMP) |-> (nxt_o == $past(tgt_i)));

  p_cmp_eq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) == OP_CMP && $past(a_i) == $past(b_i)) |-> (nxt_o == $past(seq1_i) && !wb_en_o));

  p_other_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(op_i) > OP_JMZ) |-> (nxt_o == $past(seq1_i) && !wb_en_o));
endmodule

// File: tb/br_skip_unit_tb_top.sv
module br_skip_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  op_i = '0;
  logic [11:0] tgt_i = '0, a_i = '0, b_i = '0, flags_i = '0, seq1_i = '0, seq2_i = '0;
  logic [11:0] nxt_o, wb_val_o;
  logic        wb_en_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  br_skip_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .tgt_i(tgt_i), .a_i(a_i),
    .b_i(b_i), .flags_i(flags_i), .seq1_i(seq1_i), .seq2_i(seq2_i),
    .nxt_o(nxt_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, results registered at next posedge, sample 1 ns later
  task automatic run(input logic [5:0] op, input logic [11:0] a, input logic [11:0] b,
                     input logic [11:0] fl);
    @(negedge clk_i);
    op_i = op; tgt_i = 12'h3A5; a_i = a; b_i = b; flags_i = fl;
    seq1_i = 12'h101; seq2_i = 12'h102;
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset_r1;
    op_i = 6'd13; tgt_i = 12'hFFF;
    #35;
    chk("R1 nxt", nxt_o, 12'h000);
    chk("R1 wb_en", {11'd0, wb_en_o}, 12'd0);
    chk("R1 wb_val", wb_val_o, 12'h000);
  endtask

  task automatic t_other_r2;
    run(6'd0, 12'd1, 12'd2, 12'hFFF);
    chk("R2 op0 nxt", nxt_o, 12'h101); chk("R2 op0 wb_en", {11'd0, wb_en_o}, 12'd0);
    run(6'd1, 12'd1, 12'd0, 12'hFFF);
    chk("R2 op1 nxt", nxt_o, 12'h101);
    run(6'd6, 12'd1, 12'd0, 12'h000);
    chk("R2 op6 nxt", nxt_o, 12'h101);
  endtask

  task automatic t_jmp_r3;
    run(6'd13, 12'd0, 12'd0, 12'h000);
    chk("R3 nxt", nxt_o, 12'h3A5); chk("R3 wb_en", {11'd0, wb_en_o}, 12'd0);
  endtask

  task automatic t_djn_r4;
    run(6'd7, 12'd0, 12'd5, 12'h000);
    chk("R4 b5 nxt", nxt_o, 12'h3A5); chk("R4 b5 val", wb_val_o, 12'd4);
    chk("R4 b5 en", {11'd0, wb_en_o}, 12'd1);
    run(6'd7, 12'd0, 12'd1, 12'h000);
    chk("R4 b1 nxt", nxt_o, 12'h101); chk("R4 b1 val", wb_val_o, 12'd0);
    run(6'd7, 12'd0, 12'd0, 12'h000);
    chk("R4 b0 nxt", nxt_o, 12'h3A5); chk("R4 b0 val", wb_val_o, 12'hFFF);
  endtask

  task automatic t_djz_r5;
    run(6'd8, 12'd0, 12'd1, 12'h000);
    chk("R5 b1 nxt", nxt_o, 12'h3A5); chk("R5 b1 val", wb_val_o, 12'd0);
    chk("R5 b1 en", {11'd0, wb_en_o}, 12'd1);
    run(6'd8, 12'd0, 12'd0, 12'h000);
    chk("R5 b0 nxt", nxt_o, 12'h101); chk("R5 b0 val", wb_val_o, 12'hFFF);
    run(6'd8, 12'd0, 12'd9, 12'h000);
    chk("R5 b9 nxt", nxt_o, 12'h101); chk("R5 b9 val", wb_val_o, 12'd8);
  endtask

  task automatic t_zn_r6;
    run(6'd14, 12'd0, 12'd0, 12'h000);   chk("R6 jmz 0", nxt_o, 12'h3A5);
    run(6'd14, 12'd0, 12'h800, 12'h000); chk("R6 jmz 800", nxt_o, 12'h101);
    run(6'd12, 12'd0, 12'd0, 12'h000);   chk("R6 jmn 0", nxt_o, 12'h101);
    run(6'd12, 12'd0, 12'hFFF, 12'h000); chk("R6 jmn fff", nxt_o, 12'h3A5);
  endtask

  task automatic t_jmg_r7;
    run(6'd11, 12'd0, 12'h7FF, 12'h000); chk("R7 7ff", nxt_o, 12'h3A5);
    run(6'd11, 12'd0, 12'h800, 12'h000); chk("R7 800", nxt_o, 12'h101);
    run(6'd11, 12'd0, 12'h000, 12'h000); chk("R7 000", nxt_o, 12'h101);
    run(6'd11, 12'd0, 12'h001, 12'h000); chk("R7 001", nxt_o, 12'h3A5);
    run(6'd11, 12'd0, 12'hFFF, 12'h000); chk("R7 fff", nxt_o, 12'h101);
  endtask

  task automatic t_flag_r8;
    for (int i = 9; i < 12; i++) begin
      logic [11:0] fl;
      fl = 12'h1 << i;
      run(6'd10, 12'd0, 12'(i), fl);  chk("R8 jmfs set", nxt_o, 12'h3A5);
      run(6'd10, 12'd0, 12'(i), ~fl); chk("R8 jmfs clr", nxt_o, 12'h101);
      run(6'd9, 12'd0, 12'(i), fl);   chk("R8 jmfc set", nxt_o, 12'h101);
      run(6'd9, 12'd0, 12'(i), ~fl);  chk("R8 jmfc clr", nxt_o, 12'h3A5);
    end
  endtask

  task automatic t_blind_r9;
    for (int i = 0; i < 9; i++) begin
      run(6'd10, 12'd0, 12'(i), 12'hFFF); chk("R9 jmfs low idx", nxt_o, 12'h101);
      run(6'd9, 12'd0, 12'(i), 12'hFFF);  chk("R9 jmfc low idx", nxt_o, 12'h3A5);
    end
    run(6'd10, 12'd0, 12'd12, 12'hFFF);   chk("R9 jmfs idx12", nxt_o, 12'h101);
    run(6'd9, 12'd0, 12'h80B, 12'hFFF);   chk("R9 jmfc idx80b", nxt_o, 12'h3A5);
  endtask

  task automatic t_cmp_r10;
    run(6'd5, 12'd7, 12'd8, 12'h000);
    chk("R10 differ", nxt_o, 12'h102); chk("R10 differ wb_en", {11'd0, wb_en_o}, 12'd0);
    run(6'd5, 12'h800, 12'h800, 12'h000); chk("R10 equal", nxt_o, 12'h101);
  endtask

  task automatic t_latency_r11;
    run(6'd13, 12'd0, 12'd0, 12'h000);
    @(negedge clk_i);
    op_i = 6'd1; seq1_i = 12'h555;
    #5;
    chk("R11 held before edge", nxt_o, 12'h3A5);
    @(posedge clk_i); #1;
    chk("R11 updated after edge", nxt_o, 12'h555);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_r1;
    @(negedge clk_i); rst_ni = 1'b1;
    t_other_r2;
    t_jmp_r3;
    t_djn_r4;
    t_djz_r5;
    t_zn_r6;
    t_jmg_r7;
    t_flag_r8;
    t_blind_r9;
    t_cmp_r10;
    t_latency_r11;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule